// File: doc/BRIEF.md
# System Bus Clock-Rate Generator

This block turns a stream of system core clock-enable pulses into three slower bus clock-enable strobes: one for a video pipeline, one for an AHB-style main bus and one for an APB-style peripheral bus. The main bus strobe fires on every (n+1)-th core pulse. The peripheral strobe is built from the main bus strobe and fires on every (m+1)-th of those pulses, so the peripheral bus always runs at a whole fraction of the main bus. The video strobe follows a fractional law and fires (v+1) times in every 16 core pulses.

A single write port loads a rate word. The word holds the video numerator, the two integer divisors, one stop bit per strobe and a decouple flag. The decouple flag hands the video clock to another source. While it is set, this block produces no video strobe and reports a video ratio of zero. Stop bits, the video numerator and the decouple flag take effect on the cycle after the write. A new pair of divisors waits until both divider chains reach their common terminal point, so that no bus sees a shortened period. The block also reports the ratios that are currently in force.

Top module: `sys_bus_rate_gen`

## Requirements
- R1: After synchronous reset every strobe is low, the effective video numerator and both effective divisors read 0, and the first core pulse after reset is a main-bus and a peripheral-bus tick.
- R2: With effective main divisor n, `ahb_ce` fires on every (n+1)-th core pulse, counted from the last common terminal point. Over any window of k·(n+1) core pulses it fires exactly k times.
- R3: With effective peripheral divisor m, `apb_ce` fires on every (m+1)-th main-bus tick. The peripheral period is therefore (n+1)·(m+1) core pulses.
- R4: A 4-bit phase accumulator starts at 0 and adds v+1 modulo 16 on each core pulse. `vid_ce` fires on the pulses where the sum reaches 16 or more, which gives v+1 strobes per 16 core pulses. With v=15 it fires on every core pulse.
- R5: No strobe is ever high without `core_ce`, and `apb_ce` is never high without `ahb_ce`.
- R6: A stop bit set to 1 holds its strobe low while the divider keeps counting, so the phase is kept. Stopping the main bus also holds `apb_ce` low.
- R7: While decoupled, `vid_ce` stays low, `eff_vid_n` reads 0 and the accumulator is held at 0.
- R8: A divisor write becomes effective at the next core pulse on which both the main and peripheral counters are at their terminal count (a peripheral tick). `eff_ahb_n`/`eff_apb_n` change on the cycle after that pulse and at no other time.
- R9: The video numerator, stop bits and decouple flag from a write apply from the cycle after `cfg_wr`.
- R10: If a write arrives on the same cycle as a terminal point that applies an earlier pending divisor pair, the earlier pair is applied and the new pair waits for the following terminal point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_ce | input | 1 | System core clock-enable pulse |
| cfg_wr | input | 1 | Load the rate word below |
| cfg_vid_n | input | 4 | Video numerator v (rate (v+1)/16) |
| cfg_ahb_n | input | 4 | Main-bus divisor n (rate 1/(n+1)) |
| cfg_apb_n | input | 4 | Peripheral divisor m (rate 1/(m+1) of main) |
| cfg_vid_off | input | 1 | 1 stops the video strobe |
| cfg_ahb_off | input | 1 | 1 stops the main-bus strobe (and the peripheral) |
| cfg_apb_off | input | 1 | 1 stops the peripheral strobe |
| cfg_vid_decouple | input | 1 | 1 hands the video clock elsewhere |
| vid_ce | output | 1 | Video clock-enable strobe |
| ahb_ce | output | 1 | Main-bus clock-enable strobe |
| apb_ce | output | 1 | Peripheral-bus clock-enable strobe |
| eff_vid_n | output | 4 | Video numerator in force (0 while decoupled) |
| eff_ahb_n | output | 4 | Main divisor in force |
| eff_apb_n | output | 4 | Peripheral divisor in force |

## Verification
The bench targets divisor writes that land in the middle of a peripheral period. A design that applied them at once would shorten a bus period and move `eff_ahb_n` too early. It also targets a second write that coincides with the terminal point applying the first one; a design with the wrong priority would skip the first pair or lose the second. Irregular core-pulse patterns check that the accumulator and counters advance only on core pulses. Stop-bit and decouple runs check that a stopped main bus also silences the peripheral and that re-enabling the video clock restarts its phase from zero, not from a stale accumulator value.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int DIV_W  = 4;              // integer divisor field width
    localparam int FRAC_W = 4;              // video accumulator width
    localparam int SLOTS  = 1 << FRAC_W;    // video slots per period

    // fields that take effect on the cycle after a write
    typedef struct packed {
        logic [FRAC_W-1:0] vid_n;
        logic              vid_off;
        logic              ahb_off;
        logic              apb_off;
        logic              vid_decouple;
    } live_cfg_t;

    // fields that wait for a common terminal point
    typedef struct packed {
        logic [DIV_W-1:0] ahb_n;
        logic [DIV_W-1:0] apb_n;
    } div_cfg_t;

    // accumulator step: carry bit on top, new phase below
    function automatic logic [FRAC_W:0] frac_step(input logic [FRAC_W-1:0] acc,
                                                  input logic [FRAC_W-1:0] n);
        return {1'b0, acc} + {1'b0, n} + {{FRAC_W{1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/sbr_rate_regs.sv
module sbr_rate_regs
    import sbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  live_cfg_t wr_live,
    input  div_cfg_t  wr_div,
    input  logic      boundary,
    output live_cfg_t live_q,
    output div_cfg_t  div_q,
    output div_cfg_t  div_next
);

    div_cfg_t pend_q;
    logic     pend_v;

    assign div_next = (boundary && pend_v) ? pend_q : div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            div_q  <= '0;
            pend_q <= '0;
            pend_v <= 1'b0;
        end else begin
            if (boundary && pend_v)
                div_q <= pend_q;
            if (wr_en) begin
                live_q <= wr_live;
                pend_q <= wr_div;
                pend_v <= 1'b1;
            end else if (boundary) begin
                pend_v <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sbr_int_chain.sv
module sbr_int_chain
    import sbr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     core_ce,
    input  div_cfg_t div_next,
    input  logic     ahb_off,
    input  logic     apb_off,
    output logic     ahb_ce,
    output logic     apb_ce,
    output logic     boundary
);

    logic [DIV_W-1:0] ahb_cnt;
    logic [DIV_W-1:0] apb_cnt;
    logic             ahb_tick;

    assign ahb_tick = core_ce && (ahb_cnt == '0);
    assign boundary = ahb_tick && (apb_cnt == '0);
    assign ahb_ce   = ahb_tick && !ahb_off;
    assign apb_ce   = boundary && !apb_off && !ahb_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            ahb_cnt <= '0;
            apb_cnt <= '0;
        end else if (core_ce) begin
            if (ahb_tick) begin
                ahb_cnt <= div_next.ahb_n;
                apb_cnt <= boundary ? div_next.apb_n : apb_cnt - 1'b1;
            end else begin
                ahb_cnt <= ahb_cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/sbr_frac_gen.sv
module sbr_frac_gen
    import sbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              core_ce,
    input  logic [FRAC_W-1:0] num,
    input  logic              off,
    input  logic              decouple,
    output logic              vid_ce
);

    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    assign sum    = frac_step(acc, num);
    assign vid_ce = core_ce && !decouple && !off && sum[FRAC_W];

    always_ff @(posedge clk) begin
        if (rst || decouple)
            acc <= '0;
        else if (core_ce)
            acc <= sum[FRAC_W-1:0];
    end

endmodule

// File: rtl/sys_bus_rate_gen.sv
module sys_bus_rate_gen
    import sbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              core_ce,
    input  logic              cfg_wr,
    input  logic [FRAC_W-1:0] cfg_vid_n,
    input  logic [DIV_W-1:0]  cfg_ahb_n,
    input  logic [DIV_W-1:0]  cfg_apb_n,
    input  logic              cfg_vid_off,
    input  logic              cfg_ahb_off,
    input  logic              cfg_apb_off,
    input  logic              cfg_vid_decouple,
    output logic              vid_ce,
    output logic              ahb_ce,
    output logic              apb_ce,
    output logic [FRAC_W-1:0] eff_vid_n,
    output logic [DIV_W-1:0]  eff_ahb_n,
    output logic [DIV_W-1:0]  eff_apb_n
);

    live_cfg_t wr_live, live_q;
    div_cfg_t  wr_div, div_q, div_next;
    logic      boundary;

    assign wr_live = '{vid_n: cfg_vid_n, vid_off: cfg_vid_off, ahb_off: cfg_ahb_off,
                       apb_off: cfg_apb_off, vid_decouple: cfg_vid_decouple};
    assign wr_div  = '{ahb_n: cfg_ahb_n, apb_n: cfg_apb_n};

    sbr_rate_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr),
        .wr_live  (wr_live),
        .wr_div   (wr_div),
        .boundary (boundary),
        .live_q   (live_q),
        .div_q    (div_q),
        .div_next (div_next)
    );

    sbr_int_chain u_chain (
        .clk      (clk),
        .rst      (rst),
        .core_ce  (core_ce),
        .div_next (div_next),
        .ahb_off  (live_q.ahb_off),
        .apb_off  (live_q.apb_off),
        .ahb_ce   (ahb_ce),
        .apb_ce   (apb_ce),
        .boundary (boundary)
    );

    sbr_frac_gen u_frac (
        .clk      (clk),
        .rst      (rst),
        .core_ce  (core_ce),
        .num      (live_q.vid_n),
        .off      (live_q.vid_off),
        .decouple (live_q.vid_decouple),
        .vid_ce   (vid_ce)
    );

    assign eff_vid_n = live_q.vid_decouple ? '0 : live_q.vid_n;
    assign eff_ahb_n = div_q.ahb_n;
    assign eff_apb_n = div_q.apb_n;

endmodule

// File: rtl/sbr_rate_chk.sv
module sbr_rate_chk
    import sbr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              core_ce,
    input logic              vid_ce,
    input logic              ahb_ce,
    input logic              apb_ce,
    input logic [FRAC_W-1:0] eff_vid_n,
    input logic [DIV_W-1:0]  eff_ahb_n,
    input logic [DIV_W-1:0]  eff_apb_n,
    input live_cfg_t         live_q,
    input logic              boundary
);

    AST_AHB_NEEDS_CORE: assert property (@(posedge clk) disable iff (rst)
        ahb_ce |-> core_ce);                                            // R5
    AST_VID_NEEDS_CORE: assert property (@(posedge clk) disable iff (rst)
        vid_ce |-> core_ce);                                            // R5
    AST_APB_INSIDE_AHB: assert property (@(posedge clk) disable iff (rst)
        apb_ce |-> ahb_ce);                                             // R5
    AST_AHB_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        live_q.ahb_off |-> !ahb_ce && !apb_ce);                         // R6
    AST_DECOUPLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        live_q.vid_decouple |-> !vid_ce && eff_vid_n == '0);            // R7
    AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(eff_ahb_n) && $stable(eff_apb_n));        // R8
    AST_APB_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        apb_ce |-> boundary);                                           // R3

endmodule

bind sys_bus_rate_gen sbr_rate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .core_ce   (core_ce),
    .vid_ce    (vid_ce),
    .ahb_ce    (ahb_ce),
    .apb_ce    (apb_ce),
    .eff_vid_n (eff_vid_n),
    .eff_ahb_n (eff_ahb_n),
    .eff_apb_n (eff_apb_n),
    .live_q    (live_q),
    .boundary  (boundary)
);

// File: tb/sys_bus_rate_gen_test.sv
`timescale 1ns/1ps
module sys_bus_rate_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       core_ce = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_vid_n = '0, cfg_ahb_n = '0, cfg_apb_n = '0;
    logic       cfg_vid_off = 1'b0, cfg_ahb_off = 1'b0, cfg_apb_off = 1'b0, cfg_vid_decouple = 1'b0;
    logic       vid_ce, ahb_ce, apb_ce;
    logic [3:0] eff_vid_n, eff_ahb_n, eff_apb_n;

    int checks = 0, errors = 0;
    int cnt_v = 0, cnt_a = 0, cnt_p = 0;
    bit done = 0;

    // reference model state
    int m_ac, m_pc, m_aa, m_ap, m_pa, m_pp, m_pv;
    int m_vn, m_vo, m_ao, m_po, m_dc, m_acc;

    always #2.5 clk = ~clk;   // 200 MHz

    sys_bus_rate_gen uut (.*);

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ac = 0; m_pc = 0; m_aa = 0; m_ap = 0; m_pa = 0; m_pp = 0; m_pv = 0;
        m_vn = 0; m_vo = 0; m_ao = 0; m_po = 0; m_dc = 0; m_acc = 0;
    endtask

    task automatic tick(input bit ce, input bit wr);
        int at, bt, e_a, e_p, e_v;
        @(negedge clk);
        core_ce = ce;
        cfg_wr  = wr;
        #1;
        at  = (ce && m_ac == 0) ? 1 : 0;
        bt  = (at && m_pc == 0) ? 1 : 0;
        e_a = (at && !m_ao) ? 1 : 0;
        e_p = (bt && !m_ao && !m_po) ? 1 : 0;
        e_v = (ce && !m_dc && !m_vo && (m_acc + m_vn + 1 >= 16)) ? 1 : 0;
        check(int'(ahb_ce), e_a, "R2 ahb_ce");
        check(int'(apb_ce), e_p, "R3 apb_ce");
        check(int'(vid_ce), e_v, "R4 vid_ce");
        check(int'(eff_ahb_n), m_aa, "R8 eff_ahb_n");
        check(int'(eff_apb_n), m_ap, "R8 eff_apb_n");
        check(int'(eff_vid_n), m_dc ? 0 : m_vn, "R9 eff_vid_n");
        cnt_a += int'(ahb_ce); cnt_p += int'(apb_ce); cnt_v += int'(vid_ce);
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            if (ce) begin
                if (bt) begin
                    if (m_pv) begin m_aa = m_pa; m_ap = m_pp; end
                    m_ac = m_aa; m_pc = m_ap;
                end else if (at) begin
                    m_ac = m_aa; m_pc = m_pc - 1;
                end else begin
                    m_ac = m_ac - 1;
                end
            end
            if (m_dc) m_acc = 0;
            else if (ce) m_acc = (m_acc + m_vn + 1) % 16;
            if (wr) begin
                m_pa = cfg_ahb_n; m_pp = cfg_apb_n; m_pv = 1;
                m_vn = cfg_vid_n; m_vo = cfg_vid_off; m_ao = cfg_ahb_off;
                m_po = cfg_apb_off; m_dc = cfg_vid_decouple;
            end else if (bt) begin
                m_pv = 0;
            end
        end
        #1;
        cfg_wr = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b0);
    endtask

    task automatic clear_counts();
        cnt_v = 0; cnt_a = 0; cnt_p = 0;
    endtask

    task automatic wr_cfg(input int vn, input int an, input int pn,
                          input bit vo, input bit ao, input bit po, input bit dc);
        cfg_vid_n = 4'(vn); cfg_ahb_n = 4'(an); cfg_apb_n = 4'(pn);
        cfg_vid_off = vo; cfg_ahb_off = ao; cfg_apb_off = po; cfg_vid_decouple = dc;
        tick(1'b1, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        model_reset();
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0);
        rst = 1'b0;
        tick(1'b0, 1'b0);
        // R1: reset state, nothing fires without a core pulse
        check(int'(eff_ahb_n) + int'(eff_apb_n) + int'(eff_vid_n), 0, "R1 eff ratios");
        check(int'(ahb_ce | apb_ce | vid_ce), 0, "R1 strobes idle");

        // default ratios: every core pulse for buses, 1 of 16 for video
        clear_counts(); run(16);
        check(cnt_a, 16, "R1 R2 ahb count default");
        check(cnt_p, 16, "R3 apb count default");
        check(cnt_v, 1,  "R4 vid count default");

        // n=2, m=1, v=4
        wr_cfg(4, 2, 1, 0, 0, 0, 0); run(20);
        clear_counts(); run(48);
        check(cnt_a, 16, "R2 ahb count n=2");
        check(cnt_p, 8,  "R3 apb count m=1");
        check(cnt_v, 15, "R4 vid count v=4");

        // irregular core pulses
        clear_counts();
        for (int i = 0; i < 72; i++) tick(i % 3 != 1, 1'b0);
        check(cnt_a, 16, "R5 ahb on 48 core pulses");
        check(cnt_v, 15, "R5 vid on 48 core pulses");

        // v=15: every core pulse
        wr_cfg(15, 2, 1, 0, 0, 0, 0); run(12);
        clear_counts(); run(32);
        check(cnt_v, 32, "R4 vid v=15");

        // stop main bus: peripheral silent too
        wr_cfg(15, 2, 1, 0, 1, 0, 0);
        clear_counts(); run(24);
        check(cnt_a, 0, "R6 ahb stopped");
        check(cnt_p, 0, "R6 apb stopped by ahb");
        check(cnt_v, 24, "R9 vid unaffected");
        // stop peripheral only: main phase kept
        wr_cfg(15, 2, 1, 0, 0, 1, 0);
        clear_counts(); run(24);
        check(cnt_a, 8, "R6 ahb after restart");
        check(cnt_p, 0, "R6 apb stopped");
        wr_cfg(15, 2, 1, 1, 0, 0, 0);
        clear_counts(); run(16);
        check(cnt_v, 0, "R6 vid stopped");

        // decouple, then re-couple with v=7
        wr_cfg(7, 2, 1, 0, 0, 0, 1);
        clear_counts(); run(20);
        check(cnt_v, 0, "R7 decoupled vid");
        check(int'(eff_vid_n), 0, "R7 eff_vid_n zero");
        wr_cfg(7, 2, 1, 0, 0, 0, 0);
        clear_counts(); run(16);
        check(cnt_v, 8, "R7 vid restarts from zero phase");

        // mid-period divisor change
        wr_cfg(7, 3, 2, 0, 0, 0, 0); run(30);
        begin
            int guard = 0;
            while (!apb_ce && guard < 40) begin tick(1'b1, 1'b0); guard++; end
            if (apb_ce) tick(1'b1, 1'b0);
        end
        wr_cfg(7, 0, 0, 0, 0, 0, 0);
        run(3);
        check(int'(eff_ahb_n), 3, "R8 old divisor held mid-period");
        run(12);
        check(int'(eff_ahb_n), 0, "R8 new divisor after boundary");

        // write colliding with a boundary that applies an earlier write
        wr_cfg(7, 1, 0, 0, 0, 0, 0);
        wr_cfg(7, 2, 1, 0, 0, 0, 0);
        check(int'(eff_ahb_n), 1, "R10 first pair applied");
        tick(1'b0, 1'b0);
        check(int'(eff_ahb_n), 1, "R10 second pair waits");
        run(4);
        check(int'(eff_ahb_n), 2, "R10 second pair applied");
        check(int'(eff_apb_n), 1, "R10 second apb applied");

        run(10);
        finish_run();
    end

endmodule